// File: doc/BRIEF.md
# Exception and Interrupt Control Register File

This block holds the system-control state that an in-order processor core needs in order to take traps and interrupts. It keeps four architectural registers: the faulting address, the status word, the cause word and the saved return address. Software reaches them through a register-number port, reading them with a move-from access and writing them with a move-to access. The core reports synchronous faults to the block with a code, the PC of the faulting instruction and the offending address. External devices drive a vector of interrupt lines.

When an event is accepted, the block sends fetch to a fixed handler address in the same cycle. At the next clock edge it records the event code and the resume PC, and it turns off global interrupt enable so that the handler is not entered again. A synchronous fault resumes at the instruction that faulted. An interrupt resumes at the next instruction that has not yet executed, so the instruction in flight still completes. A return pulse turns interrupt enable back on and sends fetch to the saved PC.

The register numbers are fixed: 8 is the faulting address, 12 is status, 13 is cause and 14 is the return PC. Any other number reads as zero.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, registers 8, 12, 13 and 14 read 0 while no interrupt line is pending, and `redirect_valid` is 0 while no event or return is presented.
- R2: A move-from access returns register 8, 12, 13 or 14 as selected by `reg_num`, combinationally in the same cycle. Any other register number reads 0.
- R3: While `exc_req` is high, `redirect_valid` is 1 and `redirect_pc` equals `VECTOR` (default 0x80000080) in the same cycle. After the next edge, cause bits 5:2 hold `exc_code` and register 14 holds `exc_pc`.
- R4: An interrupt is taken only when all three hold: an `irq_lines` bit is 1, the matching mask bit (status bit 8+i) is 1, and global enable (status bit 0) is 1. A taken interrupt writes code 0 to cause bits 5:2, saves `next_pc` in register 14 and redirects fetch to `VECTOR`.
- R5: If `exc_req` and an eligible interrupt occur in the same cycle, the synchronous exception is the one recorded: the code is `exc_code` and the saved PC is `exc_pc`.
- R6: Taking any event clears status bit 0 and copies its previous value into status bit 1.
- R7: When `eret` is high and `exc_req` is low, status bit 0 takes the value of status bit 1, and fetch is redirected to the current value of register 14 in that same cycle. `eret` is ignored when `exc_req` is high. An interrupt is not taken in a cycle with `eret`.
- R8: Cause bits 15:8 show `irq_lines` in every cycle. A move-to access cannot change them.
- R9: Register 8 changes only on a synchronous exception whose code is an address-error code (defaults 4 and 5). It then loads `exc_addr`. A move-to access to register 8 has no effect.
- R10: A move-to access to status writes only bits 0, 1 and 15:8. A move-to access to cause writes only bits 5:2. A move-to access to register 14 writes all 32 bits. All other bits read 0.
- R11: A move-to access presented in the same cycle as a taken event or an accepted return is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_num | input | 5 | Register number for move-from and move-to accesses |
| reg_wr | input | 1 | Move-to strobe |
| reg_wdata | input | 32 | Move-to data |
| reg_rdata | output | 32 | Move-from data |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 4 | Exception code supplied by the core |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_addr | input | 32 | Faulting data or fetch address |
| next_pc | input | 32 | PC of the next instruction not yet executed |
| irq_lines | input | 8 | External interrupt lines, active high |
| eret | input | 1 | Return-from-exception pulse |
| redirect_valid | output | 1 | Fetch must restart at `redirect_pc` |
| redirect_pc | output | 32 | New fetch address |

## Verification
The bench builds the block with its default parameters: 32-bit data, eight interrupt lines, handler vector 0x80000080, and address-error codes 4 and 5. With these values, every mask bit in status can be driven together with every interrupt line. The two address-error codes can be compared directly with non-address codes, and the full width of the return PC is covered. Directed cases cover these situations:
- a simultaneous fault and interrupt;
- a return presented together with a fault;
- a move-to access that collides with an event.

A long random run then mixes faults, returns, interrupts and register accesses.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned REGN_W   = 5;
  localparam int unsigned CODE_W   = 4;
  localparam logic [REGN_W-1:0] RN_BADADDR = 5'd8;
  localparam logic [REGN_W-1:0] RN_STATUS  = 5'd12;
  localparam logic [REGN_W-1:0] RN_CAUSE   = 5'd13;
  localparam logic [REGN_W-1:0] RN_EPC     = 5'd14;
  localparam int unsigned IE_BIT   = 0;
  localparam int unsigned PIE_BIT  = 1;
  localparam int unsigned CODE_LSB = 2;
  localparam int unsigned MASK_LSB = 8;
  localparam logic [CODE_W-1:0] CODE_IRQ = '0;

  function automatic logic is_addr_err(input logic [CODE_W-1:0] code,
                                       input logic [CODE_W-1:0] ld_code,
                                       input logic [CODE_W-1:0] st_code);
    return (code == ld_code) || (code == st_code);
  endfunction
endpackage

// File: rtl/sysctl_event_arb.sv
module sysctl_event_arb #(
  parameter int unsigned NIRQ = 8
) (
  input  logic            exc_req,
  input  logic            eret,
  input  logic            ie,
  input  logic [NIRQ-1:0] irq_lines,
  input  logic [NIRQ-1:0] irq_mask,
  output logic            take_sync,
  output logic            take_irq,
  output logic            do_eret,
  output logic            take_any
);
  function automatic logic irq_ready(input logic g_en,
                                     input logic [NIRQ-1:0] lines,
                                     input logic [NIRQ-1:0] mask);
    return g_en && (|(lines & mask));
  endfunction

  assign take_sync = exc_req;
  assign do_eret   = eret && !exc_req;
  assign take_irq  = !exc_req && !eret && irq_ready(ie, irq_lines, irq_mask);
  assign take_any  = take_sync || take_irq;
endmodule

// File: rtl/sysctl_csr_file.sv
module sysctl_csr_file
  import sysctl_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NIRQ = 8,
  parameter logic [CODE_W-1:0] LD_ADDR_CODE = 4'd4,
  parameter logic [CODE_W-1:0] ST_ADDR_CODE = 4'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REGN_W-1:0] reg_num,
  input  logic              reg_wr,
  input  logic [XLEN-1:0]   reg_wdata,
  output logic [XLEN-1:0]   reg_rdata,
  input  logic              take_sync,
  input  logic              take_irq,
  input  logic              do_eret,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic [XLEN-1:0]   exc_addr,
  input  logic [XLEN-1:0]   next_pc,
  input  logic [NIRQ-1:0]   irq_lines,
  output logic              ie,
  output logic [NIRQ-1:0]   irq_mask,
  output logic [XLEN-1:0]   epc
);
  logic              ie_q, pie_q;
  logic [NIRQ-1:0]   mask_q;
  logic [CODE_W-1:0] code_q;
  logic [XLEN-1:0]   epc_q, bad_q;

  logic take_any, sw_wr, bad_load;
  assign take_any = take_sync || take_irq;
  assign sw_wr    = reg_wr && !take_any && !do_eret;
  assign bad_load = take_sync && is_addr_err(exc_code, LD_ADDR_CODE, ST_ADDR_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      pie_q  <= 1'b0;
      mask_q <= '0;
      code_q <= '0;
      epc_q  <= '0;
      bad_q  <= '0;
    end else if (take_any) begin
      pie_q  <= ie_q;
      ie_q   <= 1'b0;
      code_q <= take_sync ? exc_code : CODE_IRQ;
      epc_q  <= take_sync ? exc_pc : next_pc;
      if (bad_load) bad_q <= exc_addr;
    end else if (do_eret) begin
      ie_q <= pie_q;
    end else if (sw_wr) begin
      case (reg_num)
        RN_STATUS: begin
          ie_q   <= reg_wdata[IE_BIT];
          pie_q  <= reg_wdata[PIE_BIT];
          mask_q <= reg_wdata[MASK_LSB +: NIRQ];
        end
        RN_CAUSE: code_q <= reg_wdata[CODE_LSB +: CODE_W];
        RN_EPC:   epc_q  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_num)
      RN_BADADDR: reg_rdata = bad_q;
      RN_STATUS: begin
        reg_rdata[IE_BIT]              = ie_q;
        reg_rdata[PIE_BIT]             = pie_q;
        reg_rdata[MASK_LSB +: NIRQ]    = mask_q;
      end
      RN_CAUSE: begin
        reg_rdata[CODE_LSB +: CODE_W]  = code_q;
        reg_rdata[MASK_LSB +: NIRQ]    = irq_lines;
      end
      RN_EPC:  reg_rdata = epc_q;
      default: reg_rdata = '0;
    endcase
  end

  assign ie       = ie_q;
  assign irq_mask = mask_q;
  assign epc      = epc_q;

  a_r6_entry_clears_ie: assert property (@(posedge clk) disable iff (!rst_n)
    take_any |=> (!ie_q && (pie_q == $past(ie_q))));
  a_r7_return_restores_ie: assert property (@(posedge clk) disable iff (!rst_n)
    do_eret |=> (ie_q == $past(pie_q)));
  a_r3_code_logged: assert property (@(posedge clk) disable iff (!rst_n)
    take_sync |=> (code_q == $past(exc_code)) && (epc_q == $past(exc_pc)));
  a_r4_irq_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> (code_q == CODE_IRQ) && (epc_q == $past(next_pc)));
  a_r9_badaddr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_load |=> $stable(bad_q));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NIRQ = 8,
  parameter logic [XLEN-1:0]   VECTOR       = 32'h8000_0080,
  parameter logic [CODE_W-1:0] LD_ADDR_CODE = 4'd4,
  parameter logic [CODE_W-1:0] ST_ADDR_CODE = 4'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REGN_W-1:0] reg_num,
  input  logic              reg_wr,
  input  logic [XLEN-1:0]   reg_wdata,
  output logic [XLEN-1:0]   reg_rdata,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic [XLEN-1:0]   exc_addr,
  input  logic [XLEN-1:0]   next_pc,
  input  logic [NIRQ-1:0]   irq_lines,
  input  logic              eret,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_pc
);
  logic            take_sync, take_irq, do_eret, take_any;
  logic            ie;
  logic [NIRQ-1:0] irq_mask;
  logic [XLEN-1:0] epc;

  sysctl_event_arb #(.NIRQ(NIRQ)) u_arb (
    .exc_req   (exc_req),
    .eret      (eret),
    .ie        (ie),
    .irq_lines (irq_lines),
    .irq_mask  (irq_mask),
    .take_sync (take_sync),
    .take_irq  (take_irq),
    .do_eret   (do_eret),
    .take_any  (take_any)
  );

  sysctl_csr_file #(
    .XLEN(XLEN), .NIRQ(NIRQ),
    .LD_ADDR_CODE(LD_ADDR_CODE), .ST_ADDR_CODE(ST_ADDR_CODE)
  ) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_num   (reg_num),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .take_sync (take_sync),
    .take_irq  (take_irq),
    .do_eret   (do_eret),
    .exc_code  (exc_code),
    .exc_pc    (exc_pc),
    .exc_addr  (exc_addr),
    .next_pc   (next_pc),
    .irq_lines (irq_lines),
    .ie        (ie),
    .irq_mask  (irq_mask),
    .epc       (epc)
  );

  assign redirect_valid = take_any || do_eret;
  assign redirect_pc    = do_eret ? epc : VECTOR;

  a_r3_fault_redirects: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (redirect_valid && (redirect_pc == VECTOR)));
  a_r5_sync_beats_irq: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> !take_irq);
  a_r4_no_irq_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie || ((irq_lines & irq_mask) == '0)) |-> !take_irq);
  a_r7_return_target: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !exc_req) |-> (redirect_valid && (redirect_pc == epc)));
endmodule

// File: tb/sysctl_regs_tb.sv
module sysctl_regs_tb;
  localparam logic [31:0] VEC = 32'h8000_0080;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_num = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        exc_req = 1'b0;
  logic [3:0]  exc_code = '0;
  logic [31:0] exc_pc = '0, exc_addr = '0, next_pc = '0;
  logic [7:0]  irq_lines = '0;
  logic        eret = 1'b0;
  logic        redirect_valid;
  logic [31:0] redirect_pc;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // reference state
  bit          m_ie, m_pie;
  logic [7:0]  m_mask;
  logic [3:0]  m_code;
  logic [31:0] m_epc, m_bad;

  always #4 clk = ~clk;

  sysctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_num(reg_num), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .exc_req(exc_req),
    .exc_code(exc_code), .exc_pc(exc_pc), .exc_addr(exc_addr),
    .next_pc(next_pc), .irq_lines(irq_lines), .eret(eret),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [4:0] rn, input logic [7:0] irq);
    case (rn)
      5'd8:    return m_bad;
      5'd12:   return {16'h0, m_mask, 6'h0, m_pie, m_ie};
      5'd13:   return {16'h0, irq, 2'b00, m_code, 2'b00};
      5'd14:   return m_epc;
      default: return 32'h0;
    endcase
  endfunction

  task automatic step(input logic er, input logic [3:0] ec, input logic [31:0] pc_i,
                      input logic [31:0] addr_i, input logic [31:0] npc_i,
                      input logic [7:0] irq, input logic et, input logic wr,
                      input logic [4:0] rn, input logic [31:0] wd, input string tag);
    bit t_sync, t_irq, t_ret, exp_v;
    logic [31:0] exp_pc;
    @(negedge clk);
    exc_req = er; exc_code = ec; exc_pc = pc_i; exc_addr = addr_i; next_pc = npc_i;
    irq_lines = irq; eret = et; reg_wr = wr; reg_num = rn; reg_wdata = wd;
    #1;
    t_sync = er;
    t_ret  = et && !er;
    t_irq  = !er && !et && m_ie && ((irq & m_mask) != 8'h0);
    exp_v  = t_sync || t_irq || t_ret;
    exp_pc = t_ret ? m_epc : VEC;
    chk(tag, "redirect_valid", {31'h0, redirect_valid}, {31'h0, exp_v});
    if (exp_v) chk(tag, "redirect_pc", redirect_pc, exp_pc);
    chk(tag, "reg_rdata", reg_rdata, model_read(rn, irq));
    @(posedge clk);
    if (t_sync || t_irq) begin
      m_pie  = m_ie;
      m_ie   = 1'b0;
      m_code = t_sync ? ec : 4'h0;
      m_epc  = t_sync ? pc_i : npc_i;
      if (t_sync && (ec == 4'd4 || ec == 4'd5)) m_bad = addr_i;
    end else if (t_ret) begin
      m_ie = m_pie;
    end else if (wr) begin
      if (rn == 5'd12) begin m_ie = wd[0]; m_pie = wd[1]; m_mask = wd[15:8]; end
      else if (rn == 5'd13) m_code = wd[5:2];
      else if (rn == 5'd14) m_epc = wd;
    end
  endtask

  task automatic rd(input logic [4:0] rn, input logic [7:0] irq, input string tag);
    step(1'b0, 4'h0, 32'h0, 32'h0, 32'h0, irq, 1'b0, 1'b0, rn, 32'h0, tag);
  endtask

  task automatic wrr(input logic [4:0] rn, input logic [31:0] wd, input string tag);
    step(1'b0, 4'h0, 32'h0, 32'h0, 32'h0, 8'h0, 1'b0, 1'b1, rn, wd, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    compared++; mismatched++;
    $display("FAIL watchdog run did not end actual=hung expected=done");
    finish_run();
  end

  initial begin
    m_ie = 0; m_pie = 0; m_mask = '0; m_code = '0; m_epc = '0; m_bad = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset values
    rd(5'd8, 8'h0, "R1"); rd(5'd12, 8'h0, "R1");
    rd(5'd13, 8'h0, "R1"); rd(5'd14, 8'h0, "R1");
    // R2 unmapped numbers read zero
    rd(5'd3, 8'h0, "R2"); rd(5'd20, 8'h0, "R2");
    // R10 field write masks
    wrr(5'd12, 32'hFFFF_FFFF, "R10"); rd(5'd12, 8'h0, "R10");
    wrr(5'd13, 32'hFFFF_FFFF, "R10"); rd(5'd13, 8'h0, "R10");
    wrr(5'd14, 32'hA5A5_5A5A, "R10"); rd(5'd14, 8'h0, "R10");
    // R4 mask bit set, global enable off: no take
    wrr(5'd12, 32'h0000_0100, "R4");
    step(1'b0, 4'h0, 32'h0, 32'h0, 32'h100, 8'h01, 1'b0, 1'b0, 5'd12, 32'h0, "R4");
    // R4 enable on, mask off: no take
    wrr(5'd12, 32'h0000_0201, "R4");
    step(1'b0, 4'h0, 32'h0, 32'h0, 32'h104, 8'h01, 1'b0, 1'b0, 5'd13, 32'h0, "R4");
    // R4 taken, with R11 move-to collision on EPC
    wrr(5'd12, 32'h0000_0101, "R4");
    step(1'b0, 4'h0, 32'h0, 32'h0, 32'h1000, 8'h01, 1'b0, 1'b1, 5'd14, 32'h7777_7777, "R11");
    rd(5'd14, 8'h00, "R4");
    rd(5'd13, 8'h5A, "R8");
    rd(5'd12, 8'h00, "R6");
    // R8 pending bits cannot be written
    wrr(5'd13, 32'h0000_FF00, "R8"); rd(5'd13, 8'h00, "R8");
    // R7 return restores enable and targets EPC
    step(1'b0, 4'h0, 32'h0, 32'h0, 32'h0, 8'h00, 1'b1, 1'b0, 5'd14, 32'h0, "R7");
    rd(5'd12, 8'h00, "R7");
    // R5 fault and eligible interrupt together
    step(1'b1, 4'hC, 32'h2000, 32'h1111_0000, 32'h2004, 8'h01, 1'b0, 1'b0, 5'd13, 32'h0, "R5");
    rd(5'd13, 8'h00, "R5"); rd(5'd14, 8'h00, "R5"); rd(5'd8, 8'h00, "R9");
    // R9 address-error codes load register 8; move-to register 8 ignored
    step(1'b1, 4'd4, 32'h3000, 32'hDEAD_BEE1, 32'h0, 8'h00, 1'b0, 1'b0, 5'd8, 32'h0, "R9");
    rd(5'd8, 8'h00, "R9");
    step(1'b1, 4'd5, 32'h3004, 32'hCAFE_0003, 32'h0, 8'h00, 1'b1, 1'b0, 5'd8, 32'h0, "R7");
    rd(5'd8, 8'h00, "R9");
    wrr(5'd8, 32'h1234_5678, "R9"); rd(5'd8, 8'h00, "R9");
    // R3 plain fault
    step(1'b1, 4'hB, 32'h4000_0010, 32'h0, 32'h0, 8'h00, 1'b0, 1'b0, 5'd14, 32'h0, "R3");
    rd(5'd14, 8'h00, "R3"); rd(5'd13, 8'h00, "R3");
    // R11 return with colliding write to status
    step(1'b0, 4'h0, 32'h0, 32'h0, 32'h0, 8'h00, 1'b1, 1'b1, 5'd12, 32'hFFFF_FFFF, "R11");
    rd(5'd12, 8'h00, "R11");
    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      logic [4:0] rn;
      case ($urandom % 6)
        0: rn = 5'd8; 1: rn = 5'd12; 2: rn = 5'd13; 3: rn = 5'd14;
        4: rn = 5'd0; default: rn = 5'd3;
      endcase
      step(($urandom % 10) == 0, 4'($urandom), $urandom, $urandom, $urandom,
           8'($urandom), ($urandom % 12) == 0, ($urandom % 3) == 0, rn,
           (($urandom % 2) == 0) ? 32'h0000_FF01 : $urandom, "R2");
    end
    finish_run();
  end
endmodule